// File: doc/BRIEF.md
# Double-Buffered Scanout Address Controller

This block times a 240 by 240 raster held in an external SRAM of 8-bit pixels that has two pages. Each scan line lasts 636 clocks in four stages: a 76-clock sync and setup stage, a 36-clock back porch, a 512-clock active stage and a 12-clock front porch. During the first 480 clocks of the active stage the block shows pixels. It steps the SRAM low address once every two clocks, asserts an active-low output enable on the data path to the DAC, and drives the row (loaded during the sync stage) on the high address. The remaining 32 active clocks stay dark.

The page-select output normally points at the hidden page, so a host can draw there. It is inverted for the pixel span only, so the visible page is read during that span. Outside the scanout window the host owns the SRAM: its address and write strobe pass through, and a ready flag tells it that access is safe. The host data driver is released two clocks before scanout begins. A one-cycle swap request is held until the first line of vertical blank. The displayed page flips there, and the new image appears from the next frame on. Each image row is repeated on two scan lines, and the 480 active lines are followed by a vertical blank.

Top module: `dbuf_scanout`

## Requirements
- R1: Each line is 636 clocks long. hsync_n is low for the first 48 clocks of the line (slots 0 to 47) and high for the rest.
- R2: On an active line (line index below ROWS*LINE_REP), dac_oe_n is low for exactly the 480 consecutive slots 112 to 591 and high elsewhere. On blank lines it is high for the whole line.
- R3: During the pixel span, sram_addr_lo equals (slot-112)/2: 0 at the first pixel, rising by one every two clocks, and 239 at the last. In the two guard slots before the span it is 0.
- R4: Throughout the scanout window (slots 110 to 591 of an active line), sram_addr_hi equals line index / LINE_REP.
- R5: sram_page equals disp_page during the pixel span and its inverse at all other times.
- R6: mem_ready is low from slot 110 through slot 591 of every active line and high on every other slot, and on every slot of blank lines.
- R7: While mem_ready is high, a host write (host_wr=1) gives sram_we_n=0 and host_drv_en=1, and sram_addr_hi/lo carry host_addr_hi/lo. While it is low, sram_we_n=1 and host_drv_en=0 whatever host_wr is.
- R8: A swap_req pulse is held pending. disp_page toggles at the first slot of line ROWS*LINE_REP (the start of vertical blank) and at no other time. Several requests before one blank give a single toggle, and with no request the page stays.
- R9: vsync_n is low on lines VS_START to VS_START+VS_W-1 and high on all other lines.
- R10: While rst_n is low: hsync_n, vsync_n, dac_oe_n and sram_we_n are high, and mem_ready, host_drv_en and disp_page are low. A reset in mid-frame returns disp_page to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-pair clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| swap_req | input | 1 | One-cycle request to show the other page |
| host_wr | input | 1 | Host write strobe, active high |
| host_addr_lo | input | 8 | Host column address |
| host_addr_hi | input | 8 | Host row address |
| sram_addr_lo | output | 8 | SRAM low address (column) |
| sram_addr_hi | output | 8 | SRAM high address (row) |
| sram_page | output | 1 | SRAM page select |
| sram_we_n | output | 1 | SRAM write enable, active low |
| host_drv_en | output | 1 | Enable for the host data-bus driver |
| dac_oe_n | output | 1 | Pixel data path to DAC enable, active low |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| mem_ready | output | 1 | High when the host may use the SRAM |
| disp_page | output | 1 | Page now being displayed |

## Verification
The bench walks every slot of a whole frame and compares each output with values worked out from the slot and line numbers. An off-by-one at the span edges would show as 479 or 481 enabled slots, or a last address of 238 or 240, and a missing guard would let host_drv_en stay high while the pixel enable falls. Page flipping is probed on both sides of the vertical-blank boundary. A design that flipped on the request itself would change disp_page mid-frame, and one that toggled per request would end on the wrong page after two requests. The host path is held in write mode across the whole frame, so any slot where a write leaks into scanout shows up as a low sram_we_n inside the window. A mid-frame reset then checks that the displayed page returns to 0.

// File: rtl/scan_pkg.sv
package scan_pkg;

    localparam int ADDR_W = 8;

    typedef struct packed {
        logic              hs_n;
        logic              vs_n;
        logic              oe_n;
        logic              page;
        logic              disp;
        logic              ready;
        logic              we_n;
        logic              drv_en;
        logic [ADDR_W-1:0] lo;
        logic [ADDR_W-1:0] hi;
    } scan_out_t;

    localparam scan_out_t OUT_RESET = '{
        hs_n:   1'b1,
        vs_n:   1'b1,
        oe_n:   1'b1,
        page:   1'b1,
        disp:   1'b0,
        ready:  1'b0,
        we_n:   1'b1,
        drv_en: 1'b0,
        lo:     '0,
        hi:     '0
    };

endpackage

// File: rtl/scan_htimer.sv
module scan_htimer #(
    parameter int H_TOTAL = 636,
    parameter int HW      = $clog2(H_TOTAL)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [HW-1:0] h_q,
    output logic          h_last
);

    localparam logic [HW-1:0] LAST = HW'(H_TOTAL - 1);

    logic [HW-1:0] h_d;

    always_comb begin
        h_last = (h_q == LAST);
        h_d    = h_last ? '0 : h_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

endmodule

// File: rtl/scan_vtimer.sv
module scan_vtimer #(
    parameter int V_TOTAL  = 525,
    parameter int ROWS     = 240,
    parameter int LINE_REP = 2,
    parameter int VW       = $clog2(V_TOTAL),
    parameter int RW       = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    output logic [VW-1:0] v_q,
    output logic [RW-1:0] row_q,
    output logic          act_line,
    output logic          last_act
);

    localparam int            ACT_LINES = ROWS * LINE_REP;
    localparam int            REPW      = (LINE_REP > 1) ? $clog2(LINE_REP) : 1;
    localparam logic [VW-1:0] V_LAST    = VW'(V_TOTAL - 1);
    localparam logic [VW-1:0] V_ACT     = VW'(ACT_LINES);
    localparam logic [VW-1:0] V_ACT_END = VW'(ACT_LINES - 1);
    localparam logic [REPW-1:0] REP_LAST = REPW'(LINE_REP - 1);
    localparam logic [RW-1:0] ROW_LAST  = RW'(ROWS - 1);

    typedef struct packed {
        logic [VW-1:0]   v;
        logic [REPW-1:0] rep;
        logic [RW-1:0]   row;
    } vstate_t;

    vstate_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (adv) begin
            if (s_q.v == V_LAST) begin
                s_d.v   = '0;
                s_d.rep = '0;
                s_d.row = '0;
            end else begin
                s_d.v = s_q.v + 1'b1;
                if (s_q.rep == REP_LAST) begin
                    s_d.rep = '0;
                    if (s_q.row != ROW_LAST) s_d.row = s_q.row + 1'b1;
                end else begin
                    s_d.rep = s_q.rep + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign v_q      = s_q.v;
    assign row_q    = s_q.row;
    assign act_line = (s_q.v < V_ACT);
    assign last_act = (s_q.v == V_ACT_END);

    // R4
    row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(adv) && act_line && $past(act_line)) |->
            (row_q == $past(row_q) || row_q == $past(row_q) + 1'b1));

endmodule

// File: rtl/scan_page_ctrl.sv
module scan_page_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic swap_req,
    input  logic flip_tick,
    output logic disp_q
);

    typedef struct packed {
        logic disp;
        logic pend;
    } pstate_t;

    pstate_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.pend = s_q.pend | swap_req;
        if (flip_tick) begin
            s_d.disp = s_q.disp ^ (s_q.pend | swap_req);
            s_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign disp_q = s_q.disp;

    // R8
    flip_only_vblank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_q != $past(disp_q)) |-> $past(flip_tick));

    // R8
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flip_tick |=> !s_q.pend);

    // R8
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_req && !flip_tick) |=> s_q.pend);

endmodule

// File: rtl/dbuf_scanout.sv
module dbuf_scanout
    import scan_pkg::*;
#(
    parameter int H_SYNC    = 76,
    parameter int H_BACK    = 36,
    parameter int H_ACT     = 512,
    parameter int H_FRONT   = 12,
    parameter int HS_W      = 48,
    parameter int PIX_COUNT = 240,
    parameter int PIX_CLKS  = 2,
    parameter int GUARD     = 2,
    parameter int ROWS      = 240,
    parameter int LINE_REP  = 2,
    parameter int V_TOTAL   = 525,
    parameter int VS_START  = 490,
    parameter int VS_W      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              swap_req,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr_lo,
    input  logic [ADDR_W-1:0] host_addr_hi,
    output logic [ADDR_W-1:0] sram_addr_lo,
    output logic [ADDR_W-1:0] sram_addr_hi,
    output logic              sram_page,
    output logic              sram_we_n,
    output logic              host_drv_en,
    output logic              dac_oe_n,
    output logic              hsync_n,
    output logic              vsync_n,
    output logic              mem_ready,
    output logic              disp_page
);

    localparam int H_TOTAL   = H_SYNC + H_BACK + H_ACT + H_FRONT;
    localparam int HW        = $clog2(H_TOTAL);
    localparam int VW        = $clog2(V_TOTAL);
    localparam int ACT_START = H_SYNC + H_BACK;
    localparam int PIX_END   = ACT_START + PIX_COUNT * PIX_CLKS;
    localparam int WIN_START = ACT_START - GUARD;
    localparam int SW        = (PIX_CLKS > 1) ? $clog2(PIX_CLKS) : 1;

    localparam logic [HW-1:0] C_HSW   = HW'(HS_W);
    localparam logic [HW-1:0] C_PRE   = HW'(ACT_START - 1);
    localparam logic [HW-1:0] C_ACT   = HW'(ACT_START);
    localparam logic [HW-1:0] C_PEND  = HW'(PIX_END);
    localparam logic [HW-1:0] C_WIN   = HW'(WIN_START);
    localparam logic [VW-1:0] C_VS0   = VW'(VS_START);
    localparam logic [VW-1:0] C_VS1   = VW'(VS_START + VS_W);
    localparam logic [SW-1:0] SUB_LAST = SW'(PIX_CLKS - 1);

    typedef struct packed {
        logic [ADDR_W-1:0] pix;
        logic [SW-1:0]     sub;
        logic [ADDR_W-1:0] row_hold;
        scan_out_t         out;
    } top_state_t;

    logic [HW-1:0]     h_q;
    logic              h_last;
    logic [VW-1:0]     v_q;
    logic [ADDR_W-1:0] row_q;
    logic              act_line;
    logic              last_act;
    logic              disp_q;
    logic              in_span;
    logic              in_win;
    logic              wr_ok;

    top_state_t s_d, s_q;

    scan_htimer #(
        .H_TOTAL (H_TOTAL),
        .HW      (HW)
    ) i_htimer (
        .clk    (clk),
        .rst_n  (rst_n),
        .h_q    (h_q),
        .h_last (h_last)
    );

    scan_vtimer #(
        .V_TOTAL  (V_TOTAL),
        .ROWS     (ROWS),
        .LINE_REP (LINE_REP),
        .VW       (VW),
        .RW       (ADDR_W)
    ) i_vtimer (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (h_last),
        .v_q      (v_q),
        .row_q    (row_q),
        .act_line (act_line),
        .last_act (last_act)
    );

    scan_page_ctrl i_page (
        .clk       (clk),
        .rst_n     (rst_n),
        .swap_req  (swap_req),
        .flip_tick (h_last && last_act),
        .disp_q    (disp_q)
    );

    always_comb begin
        s_d     = s_q;
        in_span = act_line && (h_q >= C_ACT) && (h_q < C_PEND);
        in_win  = act_line && (h_q >= C_WIN) && (h_q < C_PEND);
        wr_ok   = host_wr && !in_win;

        // Row for this line is captured during the sync stage.
        if (h_q == '0) s_d.row_hold = row_q;

        // Column counter: cleared just before the pixel span, steps per pixel.
        if (h_q == C_PRE) begin
            s_d.pix = '0;
            s_d.sub = '0;
        end else if (in_span) begin
            if (s_q.sub == SUB_LAST) begin
                s_d.sub = '0;
                s_d.pix = s_q.pix + 1'b1;
            end else begin
                s_d.sub = s_q.sub + 1'b1;
            end
        end

        s_d.out.hs_n   = (h_q >= C_HSW);
        s_d.out.vs_n   = !((v_q >= C_VS0) && (v_q < C_VS1));
        s_d.out.oe_n   = !in_span;
        s_d.out.page   = in_span ? disp_q : !disp_q;
        s_d.out.disp   = disp_q;
        s_d.out.ready  = !in_win;
        s_d.out.we_n   = !wr_ok;
        s_d.out.drv_en = wr_ok;
        s_d.out.lo     = in_win ? (in_span ? s_q.pix : '0) : host_addr_lo;
        s_d.out.hi     = in_win ? s_q.row_hold : host_addr_hi;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.pix      <= '0;
            s_q.sub      <= '0;
            s_q.row_hold <= '0;
            s_q.out      <= OUT_RESET;
        end else begin
            s_q <= s_d;
        end
    end

    assign sram_addr_lo = s_q.out.lo;
    assign sram_addr_hi = s_q.out.hi;
    assign sram_page    = s_q.out.page;
    assign sram_we_n    = s_q.out.we_n;
    assign host_drv_en  = s_q.out.drv_en;
    assign dac_oe_n     = s_q.out.oe_n;
    assign hsync_n      = s_q.out.hs_n;
    assign vsync_n      = s_q.out.vs_n;
    assign mem_ready    = s_q.out.ready;
    assign disp_page    = s_q.out.disp;

    // R2
    oe_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_oe_n |-> !mem_ready);

    // R7
    drv_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_drv_en |-> (dac_oe_n && mem_ready));

    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dac_oe_n && !$past(dac_oe_n)) |->
            (sram_addr_lo == $past(sram_addr_lo) ||
             sram_addr_lo == $past(sram_addr_lo) + 1'b1));

    // R6
    guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ready) |-> dac_oe_n);

    // R5
    page_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_oe_n |-> (sram_page == disp_page));

endmodule

// File: tb/test_dbuf_scanout.sv
module test_dbuf_scanout;

    localparam int ROWS  = 8;
    localparam int REP   = 2;
    localparam int VT    = 22;
    localparam int VS0   = 18;
    localparam int VSW   = 2;
    localparam int ACTL  = ROWS * REP;
    localparam int LINE  = 636;
    localparam int HLO   = 8'h3C;
    localparam int HHI   = 8'hA5;

    // {slot[9:0], hsync_n, dac_oe_n, mem_ready}
    localparam logic [12:0] VEC [12] = '{
        {10'd0,   3'b011}, {10'd47,  3'b011}, {10'd48,  3'b111},
        {10'd75,  3'b111}, {10'd109, 3'b111}, {10'd110, 3'b110},
        {10'd111, 3'b110}, {10'd112, 3'b100}, {10'd113, 3'b100},
        {10'd591, 3'b100}, {10'd592, 3'b111}, {10'd635, 3'b111}
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       swap_req;
    logic       host_wr;
    logic [7:0] host_addr_lo;
    logic [7:0] host_addr_hi;
    logic [7:0] sram_addr_lo;
    logic [7:0] sram_addr_hi;
    logic       sram_page;
    logic       sram_we_n;
    logic       host_drv_en;
    logic       dac_oe_n;
    logic       hsync_n;
    logic       vsync_n;
    logic       mem_ready;
    logic       disp_page;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    dbuf_scanout #(
        .ROWS     (ROWS),
        .LINE_REP (REP),
        .V_TOTAL  (VT),
        .VS_START (VS0),
        .VS_W     (VSW)
    ) i_dbuf_scanout (
        .clk          (clk),
        .rst_n        (rst_n),
        .swap_req     (swap_req),
        .host_wr      (host_wr),
        .host_addr_lo (host_addr_lo),
        .host_addr_hi (host_addr_hi),
        .sram_addr_lo (sram_addr_lo),
        .sram_addr_hi (sram_addr_hi),
        .sram_page    (sram_page),
        .sram_we_n    (sram_we_n),
        .host_drv_en  (host_drv_en),
        .dac_oe_n     (dac_oe_n),
        .hsync_n      (hsync_n),
        .vsync_n      (vsync_n),
        .mem_ready    (mem_ready),
        .disp_page    (disp_page)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_hs_fall();
        logic p;
        p = hsync_n;
        forever begin
            @(negedge clk);
            if (p && !hsync_n) break;
            p = hsync_n;
        end
    endtask

    task automatic skip_lines(input int n);
        for (int i = 0; i < n; i++) wait_hs_fall();
    endtask

    task automatic goto_line0();
        logic p;
        p = vsync_n;
        forever begin
            @(negedge clk);
            if (p && !vsync_n) break;
            p = vsync_n;
        end
        skip_lines(VT - VS0);
    endtask

    task automatic pulse_swap();
        swap_req = 1'b1;
        @(negedge clk);
        swap_req = 1'b0;
    endtask

    task automatic reset_checks(input string tag);
        chk(hsync_n == 1'b1,     "R10", {tag, " hsync_n"},     int'(hsync_n), 1);
        chk(vsync_n == 1'b1,     "R10", {tag, " vsync_n"},     int'(vsync_n), 1);
        chk(dac_oe_n == 1'b1,    "R10", {tag, " dac_oe_n"},    int'(dac_oe_n), 1);
        chk(sram_we_n == 1'b1,   "R10", {tag, " sram_we_n"},   int'(sram_we_n), 1);
        chk(mem_ready == 1'b0,   "R10", {tag, " mem_ready"},   int'(mem_ready), 0);
        chk(host_drv_en == 1'b0, "R10", {tag, " host_drv_en"}, int'(host_drv_en), 0);
        chk(disp_page == 1'b0,   "R10", {tag, " disp_page"},   int'(disp_page), 0);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected end of test");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n        = 1'b0;
        swap_req     = 1'b0;
        host_wr      = 1'b1;
        host_addr_lo = 8'(HLO);
        host_addr_hi = 8'(HHI);
        repeat (3) @(negedge clk);
        reset_checks("power-on");
        rst_n = 1'b1;

        // Full frame, every slot compared against the requirements.
        goto_line0();
        for (int ln = 0; ln < VT; ln++) begin
            int e_hs, e_oe, e_lo, e_hi, e_pg, e_rdy, e_wr, e_vs, oecnt;
            bit act;
            e_hs = 0; e_oe = 0; e_lo = 0; e_hi = 0; e_pg = 0;
            e_rdy = 0; e_wr = 0; e_vs = 0; oecnt = 0;
            act = (ln < ACTL);
            for (int s = 0; s < LINE; s++) begin
                bit span, win;
                int xlo, xhi;
                if (!(ln == 0 && s == 0)) @(negedge clk);
                span = act && s >= 112 && s < 592;
                win  = act && s >= 110 && s < 592;
                xlo  = win ? (span ? (s - 112) / 2 : 0) : HLO;
                xhi  = win ? ln / REP : HHI;
                if (!dac_oe_n) oecnt++;
                if (hsync_n != (s >= 48)) e_hs++;
                if (dac_oe_n != !span) e_oe++;
                if (int'(sram_addr_lo) != xlo) e_lo++;
                if (int'(sram_addr_hi) != xhi) e_hi++;
                if (sram_page != (span ? 1'b0 : 1'b1)) e_pg++;
                if (mem_ready != !win) e_rdy++;
                if (sram_we_n != win || host_drv_en != !win) e_wr++;
                if (vsync_n != !(ln >= VS0 && ln < VS0 + VSW)) e_vs++;
            end
            chk(e_hs == 0,  "R1", $sformatf("line %0d hsync mismatches", ln), e_hs, 0);
            chk(oecnt == (act ? 480 : 0), "R2", $sformatf("line %0d enabled slots", ln),
                oecnt, act ? 480 : 0);
            chk(e_oe == 0,  "R2", $sformatf("line %0d oe mismatches", ln), e_oe, 0);
            chk(e_lo == 0,  "R3", $sformatf("line %0d addr_lo mismatches", ln), e_lo, 0);
            chk(e_hi == 0,  "R4", $sformatf("line %0d addr_hi mismatches", ln), e_hi, 0);
            chk(e_pg == 0,  "R5", $sformatf("line %0d page mismatches", ln), e_pg, 0);
            chk(e_rdy == 0, "R6", $sformatf("line %0d ready mismatches", ln), e_rdy, 0);
            chk(e_wr == 0,  "R7", $sformatf("line %0d host path mismatches", ln), e_wr, 0);
            chk(e_vs == 0,  "R9", $sformatf("line %0d vsync mismatches", ln), e_vs, 0);
        end

        // Vector table on line 5 (row 2): slot boundaries of one line.
        skip_lines(6);
        begin
            int cur;
            cur = 0;
            for (int i = 0; i < 12; i++) begin
                int sl;
                bit span, win;
                sl = int'(VEC[i][12:3]);
                repeat (sl - cur) @(negedge clk);
                cur  = sl;
                span = sl >= 112 && sl < 592;
                win  = sl >= 110 && sl < 592;
                chk(hsync_n == VEC[i][2],   "R1", $sformatf("slot %0d hsync_n", sl),
                    int'(hsync_n), int'(VEC[i][2]));
                chk(dac_oe_n == VEC[i][1],  "R2", $sformatf("slot %0d dac_oe_n", sl),
                    int'(dac_oe_n), int'(VEC[i][1]));
                chk(mem_ready == VEC[i][0], "R6", $sformatf("slot %0d mem_ready", sl),
                    int'(mem_ready), int'(VEC[i][0]));
                chk(int'(sram_addr_lo) == (win ? (span ? (sl - 112) / 2 : 0) : HLO),
                    "R3", $sformatf("slot %0d addr_lo", sl), int'(sram_addr_lo),
                    win ? (span ? (sl - 112) / 2 : 0) : HLO);
                chk(int'(sram_addr_hi) == (win ? 2 : HHI), "R4",
                    $sformatf("slot %0d addr_hi", sl), int'(sram_addr_hi), win ? 2 : HHI);
            end
        end

        // One request in line 3: held until the start of vertical blank.
        goto_line0();
        skip_lines(3);
        pulse_swap();
        skip_lines(ACTL - 1 - 3);
        repeat (600) @(negedge clk);
        chk(disp_page == 1'b0, "R8", "page before blank", int'(disp_page), 0);
        chk(sram_page == 1'b1, "R5", "hidden page before blank", int'(sram_page), 1);
        wait_hs_fall();
        chk(disp_page == 1'b1, "R8", "page at blank start", int'(disp_page), 1);
        chk(sram_page == 1'b0, "R5", "hidden page after flip", int'(sram_page), 0);

        // Mid-frame reset returns to the reset state.
        repeat (300) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        reset_checks("mid-frame");
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Two requests before one blank give a single flip.
        goto_line0();
        skip_lines(2);
        pulse_swap();
        skip_lines(2);
        pulse_swap();
        skip_lines(ACTL - 4);
        chk(disp_page == 1'b1, "R8", "double request flips once", int'(disp_page), 1);

        // No request: the page stays through the next blank.
        skip_lines(VT);
        chk(disp_page == 1'b1, "R8", "no request keeps page", int'(disp_page), 1);
        skip_lines(VT - ACTL);
        repeat (200) @(negedge clk);
        chk(dac_oe_n == 1'b0,  "R2", "span on flipped frame", int'(dac_oe_n), 0);
        chk(sram_page == 1'b1, "R5", "visible page in span", int'(sram_page), 1);
        chk(sram_we_n == 1'b1, "R7", "write blocked in span", int'(sram_we_n), 1);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule